// File: doc/BRIEF.md
# Posted AXI Write Buffer

This block sits between an AXI master and an AXI slave on the single-beat write path. When a write's cache attribute allows buffering, the block stores the write in a local queue and answers the master with an immediate OKAY. It then replays the write to the slave in the background. The slave's answer to such a write is consumed silently. A write that may not be buffered is held until every earlier buffered write has completed at the slave. It is then forwarded, and the slave's own verdict goes back to the master.

The read address channel passes straight through, with one exception: it is gated while any write is still queued or outstanding, so a read never overtakes a buffered write. The read data channel is a plain wire-through. Lock signalling toward the slave is always normal access. Transfers are single-beat. The master presents the address and the data of a write together, and the block takes both in the same cycle.

Top module: `axi_post_wbuf`

## Requirements
- R1: A write is buffered when s_awcache[1:0] is non-zero. When those two bits are both 0, it is forwarded without buffering, whatever the value of s_awcache[3:2].
- R2: A buffered write accepted at a clock edge makes s_bvalid high after that edge, with s_bid equal to the write's ID and s_bresp = 2'b00. This does not wait for the slave.
- R3: The slave's response to a buffered write, including an error code, never appears on the master B channel.
- R4: For an unbuffered write, the master receives the slave's B response with the write's ID. The code is folded: 2'b00 and 2'b01 become 2'b00, and 2'b10 and 2'b11 become 2'b10.
- R5: An unbuffered write is issued to the slave only after every earlier buffered write has received its slave response. No early B is produced for it.
- R6: Writes reach the slave in acceptance order, with address, data, byte strobes, ID, cache and protection bits unchanged, and m_wlast = 1.
- R7: The queue holds DEPTH writes, and an entry is freed only when the slave responds to it. While the queue is full, s_awready and s_wready are low.
- R8: While any write is queued or awaiting a slave response, m_arvalid and s_arready are low. Otherwise the AR fields and the R channel pass through unchanged.
- R9: While s_bvalid is high and s_bready is low, the B fields hold steady and no write is accepted.
- R10: m_awlock is always 2'b00.
- R11: s_awready equals s_wready in every cycle; the address and data of a write are accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| s_awvalid | input | 1 | Master write address valid |
| s_awready | output | 1 | Write address accepted |
| s_awid | input | ID_W | Write ID |
| s_awaddr | input | ADDR_W | Write address |
| s_awcache | input | 4 | Cache attribute; bits 1:0 select buffering |
| s_awprot | input | 3 | Protection bits |
| s_wvalid | input | 1 | Master write data valid |
| s_wready | output | 1 | Write data accepted |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Byte strobes |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Master takes the response |
| s_bid | output | ID_W | Response ID |
| s_bresp | output | 2 | Response code |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_arid | input | ID_W | Read ID |
| s_araddr | input | ADDR_W | Read address |
| s_arprot | input | 3 | Read protection bits |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Master takes read data |
| s_rid | output | ID_W | Read data ID |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response |
| m_awvalid | output | 1 | Slave write address valid |
| m_awready | input | 1 | Slave takes the address |
| m_awid | output | ID_W | Forwarded write ID |
| m_awaddr | output | ADDR_W | Forwarded address |
| m_awcache | output | 4 | Forwarded cache attribute |
| m_awprot | output | 3 | Forwarded protection bits |
| m_awlock | output | 2 | Lock type, always normal |
| m_wvalid | output | 1 | Slave write data valid |
| m_wready | input | 1 | Slave takes the data |
| m_wdata | output | DATA_W | Forwarded data |
| m_wstrb | output | DATA_W/8 | Forwarded strobes |
| m_wlast | output | 1 | Last beat, always 1 |
| m_bvalid | input | 1 | Slave response valid |
| m_bready | output | 1 | Response taken |
| m_bid | input | ID_W | Slave response ID |
| m_bresp | input | 2 | Slave response code |
| m_arvalid | output | 1 | Gated read address valid |
| m_arready | input | 1 | Slave takes the read address |
| m_arid | output | ID_W | Read ID |
| m_araddr | output | ADDR_W | Read address |
| m_arprot | output | 3 | Read protection bits |
| m_rvalid | input | 1 | Slave read data valid |
| m_rready | output | 1 | Read data taken |
| m_rid | input | ID_W | Slave read ID |
| m_rdata | input | DATA_W | Slave read data |
| m_rresp | input | 2 | Slave read response |

## Verification
The bench instantiates the block with DEPTH = 3. This takes the queue through its non-power-of-two pointer-wrap variant, and the full condition is reached after only three held writes. The widths are ADDR_W = 32, DATA_W = 32 and ID_W = 4. The slave model derives its response code from address bits 5:4, so all four codes can be produced on demand. A hold switch on the slave keeps the queue occupied long enough to observe the full stall, the read gate and the ordering of an unbuffered write behind buffered ones.

// File: rtl/axi_wbuf_pkg.sv
package axi_wbuf_pkg;

   typedef enum logic [1:0] {
      DR_IDLE,
      DR_SEND,
      DR_WAIT
   } drain_st_e;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   // a write may be acknowledged early when either low cache bit is set
   function automatic logic post_ok(input logic [3:0] cache);
      return |cache[1:0];
   endfunction

   // collapse the four slave codes to plain success or failure
   function automatic logic [1:0] fold_resp(input logic [1:0] r);
      return r[1] ? RESP_SLVERR : RESP_OKAY;
   endfunction

endpackage

// File: rtl/wbuf_fifo.sv
module wbuf_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             full,
   output logic             empty
);

   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW   = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH > 1) && ((DEPTH & (DEPTH - 1)) == 0);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PW-1:0]    wp_q, rp_q, wp_nxt, rp_nxt;
   logic [CW-1:0]    cnt_q;

   generate
      if (POW2) begin : g_pow2
         assign wp_nxt = wp_q + 1'b1;
         assign rp_nxt = rp_q + 1'b1;
      end else begin : g_wrap
         assign wp_nxt = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nxt = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) begin
         mem[wp_q] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) begin
            wp_q <= wp_nxt;
         end
         if (pop) begin
            rp_q <= rp_nxt;
         end
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   assign dout  = mem[rp_q];
   assign full  = (cnt_q == CW'(DEPTH));
   assign empty = (cnt_q == '0);

endmodule

// File: rtl/wbuf_admit.sv
module wbuf_admit
   import axi_wbuf_pkg::*;
#(
   parameter int ID_W  = 4,
   parameter int ENT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_awvalid,
   input  logic             s_wvalid,
   input  logic [3:0]       s_awcache,
   input  logic [ID_W-1:0]  s_awid,
   input  logic [ENT_W-1:0] ent_in,
   input  logic             q_full,
   output logic             s_awready,
   output logic             s_wready,
   output logic             push,
   output logic             nb_valid,
   output logic [ENT_W-1:0] nb_ent,
   input  logic             nb_done,
   input  logic [1:0]       nb_resp,
   input  logic [ID_W-1:0]  nb_id,
   output logic             s_bvalid,
   input  logic             s_bready,
   output logic [ID_W-1:0]  s_bid,
   output logic [1:0]       s_bresp
);

   logic             both, gate, accept, nb_take;
   logic             bv_q, nb_q;
   logic [ID_W-1:0]  bid_q;
   logic [1:0]       bresp_q;
   logic [ENT_W-1:0] nb_ent_q;

   assign both    = s_awvalid & s_wvalid;
   assign gate    = !q_full && !bv_q && !nb_q;
   assign accept  = both & gate;
   assign push    = accept & post_ok(s_awcache);
   assign nb_take = accept & !post_ok(s_awcache);

   assign s_awready = accept;
   assign s_wready  = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bv_q     <= 1'b0;
         bid_q    <= '0;
         bresp_q  <= RESP_OKAY;
         nb_q     <= 1'b0;
         nb_ent_q <= '0;
      end else begin
         if (push) begin
            bv_q    <= 1'b1;
            bid_q   <= s_awid;
            bresp_q <= RESP_OKAY;
         end else if (nb_done) begin
            bv_q    <= 1'b1;
            bid_q   <= nb_id;
            bresp_q <= nb_resp;
         end else if (bv_q && s_bready) begin
            bv_q <= 1'b0;
         end
         if (nb_take) begin
            nb_q     <= 1'b1;
            nb_ent_q <= ent_in;
         end else if (nb_done) begin
            nb_q <= 1'b0;
         end
      end
   end

   assign s_bvalid = bv_q;
   assign s_bid    = bid_q;
   assign s_bresp  = bresp_q;
   assign nb_valid = nb_q;
   assign nb_ent   = nb_ent_q;

endmodule

// File: rtl/wbuf_drain.sv
module wbuf_drain
   import axi_wbuf_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int STRB_W = 4,
   parameter int ENT_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              q_empty,
   input  logic [ENT_W-1:0]  q_head,
   output logic              q_pop,
   input  logic              nb_valid,
   input  logic [ENT_W-1:0]  nb_ent,
   output logic              nb_done,
   output logic [1:0]        nb_resp,
   output logic [ID_W-1:0]   nb_id,
   output logic              cur_posted,
   output logic              m_awvalid,
   input  logic              m_awready,
   output logic [ID_W-1:0]   m_awid,
   output logic [ADDR_W-1:0] m_awaddr,
   output logic [3:0]        m_awcache,
   output logic [2:0]        m_awprot,
   output logic              m_wvalid,
   input  logic              m_wready,
   output logic [DATA_W-1:0] m_wdata,
   output logic [STRB_W-1:0] m_wstrb,
   input  logic              m_bvalid,
   output logic              m_bready,
   input  logic [ID_W-1:0]   m_bid,
   input  logic [1:0]        m_bresp
);

   drain_st_e        st_q;
   logic             posted_q, aw_done_q, w_done_q, aw_fin, w_fin;
   logic [ENT_W-1:0] cur;

   // queue head and held entry both stay stable until their response
   assign cur = posted_q ? q_head : nb_ent;
   assign {m_awid, m_awaddr, m_awcache, m_awprot, m_wdata, m_wstrb} = cur;

   assign m_awvalid = (st_q == DR_SEND) && !aw_done_q;
   assign m_wvalid  = (st_q == DR_SEND) && !w_done_q;
   assign m_bready  = (st_q == DR_WAIT);
   assign aw_fin    = aw_done_q | (m_awvalid & m_awready);
   assign w_fin     = w_done_q  | (m_wvalid & m_wready);

   always_comb begin
      q_pop   = 1'b0;
      nb_done = 1'b0;
      if (st_q == DR_WAIT && m_bvalid) begin
         if (posted_q) begin
            q_pop = 1'b1;
         end else begin
            nb_done = 1'b1;
         end
      end
   end

   assign nb_resp    = fold_resp(m_bresp);
   assign nb_id      = m_bid;
   assign cur_posted = posted_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= DR_IDLE;
         posted_q  <= 1'b1;
         aw_done_q <= 1'b0;
         w_done_q  <= 1'b0;
      end else begin
         case (st_q)
            DR_IDLE: begin
               aw_done_q <= 1'b0;
               w_done_q  <= 1'b0;
               if (!q_empty) begin
                  posted_q <= 1'b1;
                  st_q     <= DR_SEND;
               end else if (nb_valid) begin
                  posted_q <= 1'b0;
                  st_q     <= DR_SEND;
               end
            end
            DR_SEND: begin
               aw_done_q <= aw_fin;
               w_done_q  <= w_fin;
               if (aw_fin && w_fin) begin
                  st_q <= DR_WAIT;
               end
            end
            DR_WAIT: begin
               if (m_bvalid) begin
                  st_q <= DR_IDLE;
               end
            end
            default: st_q <= DR_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/axi_post_wbuf.sv
module axi_post_wbuf
   import axi_wbuf_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int ID_W   = 4,
   parameter int DEPTH  = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                s_awvalid,
   output logic                s_awready,
   input  logic [ID_W-1:0]     s_awid,
   input  logic [ADDR_W-1:0]   s_awaddr,
   input  logic [3:0]          s_awcache,
   input  logic [2:0]          s_awprot,
   input  logic                s_wvalid,
   output logic                s_wready,
   input  logic [DATA_W-1:0]   s_wdata,
   input  logic [DATA_W/8-1:0] s_wstrb,
   output logic                s_bvalid,
   input  logic                s_bready,
   output logic [ID_W-1:0]     s_bid,
   output logic [1:0]          s_bresp,
   input  logic                s_arvalid,
   output logic                s_arready,
   input  logic [ID_W-1:0]     s_arid,
   input  logic [ADDR_W-1:0]   s_araddr,
   input  logic [2:0]          s_arprot,
   output logic                s_rvalid,
   input  logic                s_rready,
   output logic [ID_W-1:0]     s_rid,
   output logic [DATA_W-1:0]   s_rdata,
   output logic [1:0]          s_rresp,
   output logic                m_awvalid,
   input  logic                m_awready,
   output logic [ID_W-1:0]     m_awid,
   output logic [ADDR_W-1:0]   m_awaddr,
   output logic [3:0]          m_awcache,
   output logic [2:0]          m_awprot,
   output logic [1:0]          m_awlock,
   output logic                m_wvalid,
   input  logic                m_wready,
   output logic [DATA_W-1:0]   m_wdata,
   output logic [DATA_W/8-1:0] m_wstrb,
   output logic                m_wlast,
   input  logic                m_bvalid,
   output logic                m_bready,
   input  logic [ID_W-1:0]     m_bid,
   input  logic [1:0]          m_bresp,
   output logic                m_arvalid,
   input  logic                m_arready,
   output logic [ID_W-1:0]     m_arid,
   output logic [ADDR_W-1:0]   m_araddr,
   output logic [2:0]          m_arprot,
   input  logic                m_rvalid,
   output logic                m_rready,
   input  logic [ID_W-1:0]     m_rid,
   input  logic [DATA_W-1:0]   m_rdata,
   input  logic [1:0]          m_rresp
);

   localparam int STRB_W = DATA_W / 8;
   localparam int ENT_W  = ID_W + ADDR_W + 4 + 3 + DATA_W + STRB_W;

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("axi_post_wbuf: DEPTH must be at least 1");
      end
      if ((DATA_W % 8) != 0 || DATA_W < 8) begin : g_bad_data
         $error("axi_post_wbuf: DATA_W must be a positive multiple of 8");
      end
      if (ID_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("axi_post_wbuf: ID_W and ADDR_W must be positive");
      end
   endgenerate

   logic             push, q_pop, q_full, q_empty;
   logic             nb_valid, nb_done, cur_posted, rd_open;
   logic [1:0]       nb_resp;
   logic [ID_W-1:0]  nb_id;
   logic [ENT_W-1:0] ent_in, q_head, nb_ent;

   assign ent_in = {s_awid, s_awaddr, s_awcache, s_awprot, s_wdata, s_wstrb};

   wbuf_admit #(
      .ID_W  (ID_W),
      .ENT_W (ENT_W)
   ) u_admit (
      .clk       (clk),
      .rst_n     (rst_n),
      .s_awvalid (s_awvalid),
      .s_wvalid  (s_wvalid),
      .s_awcache (s_awcache),
      .s_awid    (s_awid),
      .ent_in    (ent_in),
      .q_full    (q_full),
      .s_awready (s_awready),
      .s_wready  (s_wready),
      .push      (push),
      .nb_valid  (nb_valid),
      .nb_ent    (nb_ent),
      .nb_done   (nb_done),
      .nb_resp   (nb_resp),
      .nb_id     (nb_id),
      .s_bvalid  (s_bvalid),
      .s_bready  (s_bready),
      .s_bid     (s_bid),
      .s_bresp   (s_bresp)
   );

   wbuf_fifo #(
      .WIDTH (ENT_W),
      .DEPTH (DEPTH)
   ) u_queue (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (push),
      .din   (ent_in),
      .pop   (q_pop),
      .dout  (q_head),
      .full  (q_full),
      .empty (q_empty)
   );

   wbuf_drain #(
      .ID_W   (ID_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STRB_W (STRB_W),
      .ENT_W  (ENT_W)
   ) u_drain (
      .clk        (clk),
      .rst_n      (rst_n),
      .q_empty    (q_empty),
      .q_head     (q_head),
      .q_pop      (q_pop),
      .nb_valid   (nb_valid),
      .nb_ent     (nb_ent),
      .nb_done    (nb_done),
      .nb_resp    (nb_resp),
      .nb_id      (nb_id),
      .cur_posted (cur_posted),
      .m_awvalid  (m_awvalid),
      .m_awready  (m_awready),
      .m_awid     (m_awid),
      .m_awaddr   (m_awaddr),
      .m_awcache  (m_awcache),
      .m_awprot   (m_awprot),
      .m_wvalid   (m_wvalid),
      .m_wready   (m_wready),
      .m_wdata    (m_wdata),
      .m_wstrb    (m_wstrb),
      .m_bvalid   (m_bvalid),
      .m_bready   (m_bready),
      .m_bid      (m_bid),
      .m_bresp    (m_bresp)
   );

   assign m_awlock = 2'b00;
   assign m_wlast  = 1'b1;

   // entries leave the queue only on their slave response, so this covers in-flight writes
   assign rd_open   = q_empty && !nb_valid;
   assign m_arvalid = s_arvalid & rd_open;
   assign s_arready = m_arready & rd_open;
   assign m_arid    = s_arid;
   assign m_araddr  = s_araddr;
   assign m_arprot  = s_arprot;

   assign s_rvalid = m_rvalid;
   assign m_rready = s_rready;
   assign s_rid    = m_rid;
   assign s_rdata  = m_rdata;
   assign s_rresp  = m_rresp;

endmodule

// File: rtl/wbuf_checker.sv
module wbuf_checker #(
   parameter int ID_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            s_awvalid,
   input logic            s_awready,
   input logic            s_wready,
   input logic [ID_W-1:0] s_awid,
   input logic [3:0]      s_awcache,
   input logic            s_bvalid,
   input logic            s_bready,
   input logic [ID_W-1:0] s_bid,
   input logic [1:0]      s_bresp,
   input logic            m_awvalid,
   input logic            m_awready,
   input logic            m_bvalid,
   input logic            m_bready,
   input logic            m_arvalid,
   input logic            q_full,
   input logic            q_empty,
   input logic            cur_posted
);

   logic [1:0] outst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outst_q <= '0;
      end else if (m_awvalid && m_awready) begin
         outst_q <= outst_q + 1'b1;
      end else if (m_bvalid && m_bready) begin
         outst_q <= outst_q - 1'b1;
      end
   end

   assert_ready_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
      s_awready == s_wready);

   assert_early_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_awvalid && s_awready && (|s_awcache[1:0]))
      |=> (s_bvalid && s_bresp == 2'b00 && s_bid == $past(s_awid)));

   assert_b_steady_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |=> (s_bvalid && $stable(s_bid) && $stable(s_bresp)));

   assert_b_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (s_bvalid && !s_bready) |-> !s_awready);

   assert_resp_folded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      s_bvalid |-> !s_bresp[0]);

   assert_full_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !s_awready);

   assert_unbuf_after_posted_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (m_awvalid && !cur_posted) |-> q_empty);

   assert_read_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (outst_q != 2'd0) |-> !m_arvalid);

endmodule

bind axi_post_wbuf wbuf_checker #(.ID_W(ID_W)) u_wbuf_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .s_awvalid  (s_awvalid),
   .s_awready  (s_awready),
   .s_wready   (s_wready),
   .s_awid     (s_awid),
   .s_awcache  (s_awcache),
   .s_bvalid   (s_bvalid),
   .s_bready   (s_bready),
   .s_bid      (s_bid),
   .s_bresp    (s_bresp),
   .m_awvalid  (m_awvalid),
   .m_awready  (m_awready),
   .m_bvalid   (m_bvalid),
   .m_bready   (m_bready),
   .m_arvalid  (m_arvalid),
   .q_full     (q_full),
   .q_empty    (q_empty),
   .cur_posted (cur_posted)
);

// File: tb/axi_post_wbuf_test.sv
module axi_post_wbuf_test;

   localparam int QD = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_bready = 1'b1;
   logic        s_arvalid = 1'b0, s_rready = 1'b1;
   logic [3:0]  s_awid = '0, s_arid = '0;
   logic [31:0] s_awaddr = '0, s_wdata = '0, s_araddr = '0;
   logic [3:0]  s_awcache = '0, s_wstrb = '0;
   logic [2:0]  s_awprot = '0, s_arprot = '0;
   wire         s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
   wire  [3:0]  s_bid, s_rid;
   wire  [1:0]  s_bresp, s_rresp;
   wire  [31:0] s_rdata;

   wire         m_awvalid, m_wvalid, m_bready, m_wlast, m_arvalid, m_rready;
   wire  [3:0]  m_awid, m_awcache, m_wstrb, m_arid;
   wire  [31:0] m_awaddr, m_wdata, m_araddr;
   wire  [2:0]  m_awprot, m_arprot;
   wire  [1:0]  m_awlock;
   logic        m_arready = 1'b1, m_rvalid = 1'b0;
   logic [3:0]  m_rid = '0;
   logic [31:0] m_rdata = '0;
   logic [1:0]  m_rresp = '0;

   // slave model
   logic        slv_hold = 1'b0, pend = 1'b0, sbv = 1'b0;
   logic [3:0]  sbid = '0;
   logic [1:0]  sbresp = '0;
   logic [1:0]  lat = '0;
   wire         m_awready = !slv_hold && !pend;
   wire         m_wready  = !slv_hold && !pend;

   axi_post_wbuf #(.ADDR_W(32), .DATA_W(32), .ID_W(4), .DEPTH(QD)) uut (
      .clk(clk), .rst_n(rst_n),
      .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awid(s_awid), .s_awaddr(s_awaddr),
      .s_awcache(s_awcache), .s_awprot(s_awprot),
      .s_wvalid(s_wvalid), .s_wready(s_wready), .s_wdata(s_wdata), .s_wstrb(s_wstrb),
      .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bid(s_bid), .s_bresp(s_bresp),
      .s_arvalid(s_arvalid), .s_arready(s_arready), .s_arid(s_arid), .s_araddr(s_araddr),
      .s_arprot(s_arprot),
      .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rid(s_rid), .s_rdata(s_rdata), .s_rresp(s_rresp),
      .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awid(m_awid), .m_awaddr(m_awaddr),
      .m_awcache(m_awcache), .m_awprot(m_awprot), .m_awlock(m_awlock),
      .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wlast(m_wlast),
      .m_bvalid(sbv), .m_bready(m_bready), .m_bid(sbid), .m_bresp(sbresp),
      .m_arvalid(m_arvalid), .m_arready(m_arready), .m_arid(m_arid), .m_araddr(m_araddr),
      .m_arprot(m_arprot),
      .m_rvalid(m_rvalid), .m_rready(m_rready), .m_rid(m_rid), .m_rdata(m_rdata), .m_rresp(m_rresp)
   );

   always #5 clk = ~clk;

   always @(posedge clk) begin
      if (m_awvalid && m_awready) begin
         pend   <= 1'b1;
         sbid   <= m_awid;
         sbresp <= m_awaddr[5:4];
         lat    <= 2'd2;
      end else if (pend && !sbv) begin
         if (lat == 2'd0) sbv <= 1'b1;
         else             lat <= lat - 1'b1;
      end
      if (sbv && m_bready) begin
         sbv  <= 1'b0;
         pend <= 1'b0;
      end
   end

   typedef struct {
      logic [3:0]  id;
      logic [31:0] addr;
      logic [31:0] data;
      logic [3:0]  cache;
      logic [2:0]  prot;
   } sw_item_t;

   typedef struct {
      logic [3:0] id;
      logic [1:0] resp;
   } b_item_t;

   sw_item_t exp_sw[$];
   b_item_t  exp_b[$];
   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [1:0] exp_fold(input logic [1:0] r);
      return r[1] ? 2'b10 : 2'b00;
   endfunction

   // B scoreboard monitor
   always begin
      @(negedge clk);
      #3;
      if (s_bvalid && s_bready) begin
         if (exp_b.size() == 0) begin
            chk(1'b0, "R3", "unexpected B response", 64'(s_bid), 64'hF);
         end else begin
            b_item_t e;
            e = exp_b.pop_front();
            chk(s_bid == e.id, "R2 R4", "B id", 64'(s_bid), 64'(e.id));
            chk(s_bresp == e.resp, "R1 R4", "B code", 64'(s_bresp), 64'(e.resp));
         end
      end
   end

   // slave-side write monitor
   always begin
      @(negedge clk);
      #3;
      if (m_awvalid && m_awready) begin
         if (exp_sw.size() == 0) begin
            chk(1'b0, "R6", "unexpected slave write", 64'(m_awaddr), 64'h0);
         end else begin
            sw_item_t e;
            e = exp_sw.pop_front();
            chk(m_awaddr == e.addr && m_awid == e.id, "R6", "slave addr/id",
                {28'(m_awid), m_awaddr}, {28'(e.id), e.addr});
            chk(m_wvalid && m_wready && m_wdata == e.data && m_wstrb == 4'hF && m_wlast,
                "R6", "slave data", 64'(m_wdata), 64'(e.data));
            chk(m_awcache == e.cache && m_awprot == e.prot, "R6", "cache/prot",
                64'({m_awcache, m_awprot}), 64'({e.cache, e.prot}));
            chk(m_awlock == 2'b00, "R10", "lock", 64'(m_awlock), 64'h0);
         end
      end
   end

   task automatic do_write(input logic [3:0] id, input logic [31:0] addr,
                           input logic [31:0] data, input logic [3:0] cache,
                           input logic [2:0] prot);
      logic posted;
      sw_item_t s;
      b_item_t b;
      posted = |cache[1:0];
      @(negedge clk);
      s_awvalid = 1'b1; s_wvalid = 1'b1;
      s_awid = id; s_awaddr = addr; s_wdata = data; s_awcache = cache;
      s_awprot = prot; s_wstrb = 4'hF;
      #1;
      while (!s_awready) begin
         @(negedge clk);
         #1;
      end
      chk(s_awready == s_wready, "R11", "AW/W ready pair", 64'(s_wready), 64'(s_awready));
      s.id = id; s.addr = addr; s.data = data; s.cache = cache; s.prot = prot;
      exp_sw.push_back(s);
      b.id = id;
      b.resp = posted ? 2'b00 : exp_fold(addr[5:4]);
      exp_b.push_back(b);
      @(posedge clk);
      #1;
      s_awvalid = 1'b0; s_wvalid = 1'b0;
      if (posted) begin
         @(negedge clk);
         #1;
         chk(s_bvalid && s_bid == id && s_bresp == 2'b00, "R2", "early B",
             64'({s_bvalid, s_bid, s_bresp}), 64'({1'b1, id, 2'b00}));
      end
   endtask

   task automatic wait_drain;
      for (int i = 0; i < 3000; i++) begin
         if (exp_b.size() == 0 && exp_sw.size() == 0 && !pend && !m_awvalid) break;
         @(negedge clk);
      end
      repeat (8) @(negedge clk);
      chk(exp_b.size() == 0 && exp_sw.size() == 0, "R6", "all writes drained",
          64'(exp_b.size() + exp_sw.size()), 64'h0);
   endtask

   task automatic set_at_pos(output logic v, input logic val);
      @(posedge clk);
      #1;
      v = val;
   endtask

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "R6", "watchdog expired", 64'h0, 64'h1);
      report();
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #1;
      rst_n = 1'b1;
      @(negedge clk);
      #1;
      chk(!s_bvalid && !m_awvalid && !s_awready, "R2", "reset idle",
          64'({s_bvalid, m_awvalid, s_awready}), 64'h0);
      chk(m_awlock == 2'b00 && m_wlast, "R10", "reset lock/last",
          64'({m_awlock, m_wlast}), 64'h1);

      // R1 classification, R2 early ack, R3 dropped errors, R4 code folding
      do_write(4'h1, 32'h0000_1020, 32'hA1A1_0001, 4'b0011, 3'b010);
      do_write(4'h2, 32'h0000_1030, 32'hA2A2_0002, 4'b0001, 3'b011);
      do_write(4'h3, 32'h0000_1120, 32'hA3A3_0003, 4'b0010, 3'b000);
      do_write(4'h4, 32'h0000_2010, 32'hB4B4_0004, 4'b0000, 3'b010);
      do_write(4'h5, 32'h0000_2030, 32'hB5B5_0005, 4'b0100, 3'b001);
      do_write(4'h6, 32'h0000_2020, 32'hB6B6_0006, 4'b1000, 3'b010);
      do_write(4'h7, 32'h0000_2000, 32'hB7B7_0007, 4'b1100, 3'b110);
      wait_drain();
      chk(!s_bvalid, "R3", "no B left after posted errors", 64'(s_bvalid), 64'h0);

      // R7 full stall and R8 read gate
      set_at_pos(slv_hold, 1'b1);
      for (int k = 0; k < QD; k++) begin
         do_write(4'(8 + k), 32'h0000_3000 + 32'(k * 16), 32'hC0C0_0000 + 32'(k), 4'b0011, 3'b010);
      end
      fork
         do_write(4'hE, 32'h0000_3100, 32'hC0C0_00EE, 4'b0001, 3'b010);
      join_none
      @(negedge clk);
      s_arvalid = 1'b1; s_araddr = 32'h0000_3000; s_arid = 4'h9; s_arprot = 3'b010;
      repeat (3) @(negedge clk);
      #2;
      chk(!s_awready, "R7", "awready low when full", 64'(s_awready), 64'h0);
      chk(!m_arvalid && !s_arready, "R8", "read gated while queued",
          64'({m_arvalid, s_arready}), 64'h0);
      set_at_pos(slv_hold, 1'b0);
      wait_drain();
      #2;
      chk(m_arvalid && s_arready && m_araddr == 32'h0000_3000 && m_arid == 4'h9 && m_arprot == 3'b010,
          "R8", "read passes when idle", 64'({m_arvalid, s_arready}), 64'h3);
      m_rvalid = 1'b1; m_rdata = 32'h5A5A_1234; m_rid = 4'h9; m_rresp = 2'b01;
      #1;
      chk(s_rvalid && s_rdata == 32'h5A5A_1234 && s_rid == 4'h9 && s_rresp == 2'b01 && m_rready,
          "R8", "R channel pass-through", 64'(s_rdata), 64'h5A5A_1234);
      @(negedge clk);
      s_arvalid = 1'b0; m_rvalid = 1'b0;

      // R5 unbuffered write waits behind posted ones
      set_at_pos(slv_hold, 1'b1);
      do_write(4'h1, 32'h0000_4000, 32'hD0D0_0001, 4'b0011, 3'b010);
      do_write(4'h2, 32'h0000_4010, 32'hD0D0_0002, 4'b0010, 3'b010);
      do_write(4'h3, 32'h0000_4030, 32'hD0D0_0003, 4'b0000, 3'b010);
      repeat (4) @(negedge clk);
      #2;
      chk(!s_bvalid, "R5", "no early B for unbuffered", 64'(s_bvalid), 64'h0);
      chk(exp_b.size() == 1, "R5", "unbuffered B outstanding", 64'(exp_b.size()), 64'h1);
      set_at_pos(slv_hold, 1'b0);
      wait_drain();

      // R9 pending B blocks further writes
      set_at_pos(s_bready, 1'b0);
      do_write(4'hA, 32'h0000_5000, 32'hE0E0_000A, 4'b0011, 3'b010);
      fork
         do_write(4'hB, 32'h0000_5010, 32'hE0E0_000B, 4'b0011, 3'b010);
      join_none
      repeat (4) @(negedge clk);
      #2;
      chk(s_bvalid && s_bid == 4'hA && s_bresp == 2'b00, "R9", "B held",
          64'({s_bvalid, s_bid}), 64'h1A);
      chk(!s_awready, "R9", "no accept while B pending", 64'(s_awready), 64'h0);
      set_at_pos(s_bready, 1'b1);
      wait_drain();

      report();
      $finish;
   end

endmodule